// File: doc/BRIEF.md
# Filtered input capture channel

This block is one capture channel that sits next to a free-running counter. An asynchronous pin enters through a two-flop synchronizer. A digital glitch filter then accepts a new pin level only after that level has been seen for a programmable number of consecutive clock samples. The filtered level is checked for the selected edge polarity. The valid edges go through an optional edge prescaler. Each event the prescaler lets through copies the counter value into the capture register and sets the capture flag.

A four-state flag machine holds the capture flag and the overcapture flag. Its states are EMPTY (no flag), HELD (capture flag only), LOST (overcapture flag only) and HELD_LOST (both flags). Its transitions are:
- *arm*: EMPTY to HELD.
- *overrun*: HELD or LOST to HELD_LOST.
- *consume*: HELD to EMPTY, or HELD_LOST to LOST.
- *acknowledge*: LOST to EMPTY, or HELD_LOST to HELD.
- *purge*: HELD_LOST to EMPTY.
- *rearm*: LOST to HELD.

Software clears the flags with write strobes. A read strobe on the capture register also clears the capture flag. A software generate strobe sets the capture flag without taking a sample. An interrupt request follows the capture flag while the interrupt is enabled.

Top module: `capch_top`

## Requirements
- R1: While reset is asserted and right after it is released, `cap_flag`, `ovr_flag`, `irq` and `cap_val` are all zero.
- R2: On each capture event, `cap_val` takes the value of `cnt_in` and `cap_flag` is set. With filter code 0, a pin change that is driven before clock edge k is captured at edge k+3.
- R3: When `edge_pol` is 0 the rising edge is active, and when it is 1 the falling edge is active. The opposite edge captures nothing.
- R4: Filter code 0 accepts a level after 1 sample. Codes 1, 2 and 3 need 2, 4 and 8 consecutive samples. Codes 4 to 15 need 8*(code-2) samples. A pulse shorter than the required count leaves `cap_val` and `cap_flag` unchanged.
- R5: Prescaler code 0, 1, 2 or 3 makes a capture on every 1st, 2nd, 4th or 8th active edge.
- R6: While `chan_en` is 0 no capture happens. The prescaler edge count is also cleared, so counting starts again when the channel is re-enabled.
- R7: A capture event while `cap_flag` is already set also sets `ovr_flag`. A software generate strobe never sets `ovr_flag`.
- R8: A `clr_cap_wr` or `cap_rd` strobe clears `cap_flag` on the next edge. Only `clr_ovr_wr` clears `ovr_flag`.
- R9: When a capture event and a clear strobe fall in the same cycle, the capture wins and the flag stays set. This holds for `cap_flag` and for `ovr_flag`.
- R10: `irq` is high exactly when `cap_flag` and `irq_en` are both high. It is combinational from `irq_en`.
- R11: A `sw_gen` strobe sets `cap_flag` on the next edge and leaves `cap_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_in | input | CNT_W | Value of the free-running counter |
| pin_in | input | 1 | Asynchronous capture pin |
| chan_en | input | 1 | Channel capture enable |
| edge_pol | input | 1 | 0 = rising edge active, 1 = falling edge active |
| flt_code | input | 4 | Glitch filter length code |
| psc_code | input | PSC_W | Edge prescaler code |
| irq_en | input | 1 | Interrupt enable |
| sw_gen | input | 1 | Software strobe that sets the capture flag |
| clr_cap_wr | input | 1 | Write strobe that clears the capture flag |
| clr_ovr_wr | input | 1 | Write strobe that clears the overcapture flag |
| cap_rd | input | 1 | Read strobe on the capture register |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a two-stage synchronizer, a two-bit prescaler code and a seven-bit filter run counter. With these values, filter lengths up to 16 samples (code 4) can be tested with pulses one sample shorter and exactly as long as the limit. All four prescaler ratios up to divide-by-8 can also be reached. Filter code 0 has a short, known latency, so a read strobe can be placed in exactly the cycle of a capture.

// File: rtl/capch_pkg.sv
package capch_pkg;

    localparam int FLT_CODE_W = 4;

    // bit 1 = overcapture flag, bit 0 = capture flag
    typedef enum logic [1:0] {
        FS_EMPTY     = 2'b00,
        FS_HELD      = 2'b01,
        FS_LOST      = 2'b10,
        FS_HELD_LOST = 2'b11
    } flag_state_e;

    // consecutive samples needed before the filter adopts a new level
    function automatic int unsigned flt_len(input logic [FLT_CODE_W-1:0] code);
        if (code == '0)
            return 32'd1;
        else if (code < 4'd4)
            return 32'd1 << code;
        else
            return 32'd8 * (32'(code) - 32'd2);
    endfunction

endpackage

// File: rtl/capch_sync.sv
module capch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/capch_filter.sv
module capch_filter
    import capch_pkg::*;
#(
    parameter int RUN_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp,
    input  logic [FLT_CODE_W-1:0] code,
    output logic                  lvl
);
    localparam int NW = RUN_W + 1;

    logic [RUN_W-1:0] run;
    logic [NW-1:0]    run_nx;
    logic [NW-1:0]    need;

    assign need   = NW'(flt_len(code));
    assign run_nx = {1'b0, run} + {{RUN_W{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= 1'b0;
            run <= '0;
        end else if (smp == lvl) begin
            run <= '0;
        end else if (run_nx >= need) begin
            lvl <= smp;
            run <= '0;
        end else begin
            run <= run_nx[RUN_W-1:0];
        end
    end
endmodule

// File: rtl/capch_prescale.sv
module capch_prescale #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_in,
    input  logic [PSC_W-1:0] code,
    output logic             fire
);
    localparam int DW = (1 << PSC_W) - 1;

    logic [DW-1:0] cnt;
    logic [DW-1:0] last;

    assign last = DW'((32'd1 << code) - 32'd1);
    assign fire = en & edge_in & (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en)
            cnt <= '0;
        else if (edge_in)
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/capch_top.sv
module capch_top
    import capch_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2,
    parameter int PSC_W  = 2,
    parameter int RUN_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      cnt_in,
    input  logic                  pin_in,
    input  logic                  chan_en,
    input  logic                  edge_pol,
    input  logic [FLT_CODE_W-1:0] flt_code,
    input  logic [PSC_W-1:0]      psc_code,
    input  logic                  irq_en,
    input  logic                  sw_gen,
    input  logic                  clr_cap_wr,
    input  logic                  clr_ovr_wr,
    input  logic                  cap_rd,
    output logic [CNT_W-1:0]      cap_val,
    output logic                  cap_flag,
    output logic                  ovr_flag,
    output logic                  irq
);
    logic        pin_s;
    logic        lvl;
    logic        lvl_d;
    logic        act_edge;
    logic        cap_evt;
    logic        clr_c;
    logic        keep_c;
    logic        keep_o;
    flag_state_e state;
    flag_state_e nxt;

    capch_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    capch_filter #(.RUN_W(RUN_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .smp(pin_s), .code(flt_code), .lvl(lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lvl_d <= 1'b0;
        else
            lvl_d <= lvl;
    end

    assign act_edge = edge_pol ? (lvl_d & ~lvl) : (lvl & ~lvl_d);

    capch_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(chan_en), .edge_in(act_edge),
        .code(psc_code), .fire(cap_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_val <= '0;
        else if (cap_evt)
            cap_val <= cnt_in;
    end

    assign clr_c  = clr_cap_wr | cap_rd;
    assign keep_c = sw_gen | ~clr_c;
    assign keep_o = ~clr_ovr_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= FS_EMPTY;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            FS_EMPTY: begin
                if (cap_evt || sw_gen) nxt = FS_HELD;                // arm
            end
            FS_HELD: begin
                if (cap_evt)      nxt = FS_HELD_LOST;                // overrun
                else if (!keep_c) nxt = FS_EMPTY;                    // consume
            end
            FS_LOST: begin
                if (cap_evt || sw_gen)
                    nxt = keep_o ? FS_HELD_LOST : FS_HELD;           // rearm
                else if (!keep_o)
                    nxt = FS_EMPTY;                                  // acknowledge
            end
            FS_HELD_LOST: begin
                if (cap_evt)
                    nxt = FS_HELD_LOST;
                else
                    nxt = flag_state_e'({keep_o, keep_c});           // consume/acknowledge/purge
            end
            default: nxt = FS_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        cap_flag = 1'b0;
        ovr_flag = 1'b0;
        unique case (state)
            FS_EMPTY:     begin cap_flag = 1'b0; ovr_flag = 1'b0; end
            FS_HELD:      begin cap_flag = 1'b1; ovr_flag = 1'b0; end
            FS_LOST:      begin cap_flag = 1'b0; ovr_flag = 1'b1; end
            FS_HELD_LOST: begin cap_flag = 1'b1; ovr_flag = 1'b1; end
            default:      begin cap_flag = 1'b0; ovr_flag = 1'b0; end
        endcase
    end

    assign irq = cap_flag & irq_en;
endmodule

// File: rtl/capch_chk.sv
module capch_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             ovr_flag,
    input logic             irq,
    input logic             irq_en,
    input logic             chan_en,
    input logic             sw_gen,
    input logic             clr_cap_wr,
    input logic             clr_ovr_wr,
    input logic             cap_rd
);
    // R2
    capval_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> cap_flag);

    // R6
    capval_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> $past(chan_en));

    // R7
    ovr_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(cap_flag));

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_ovr_wr) |=> ovr_flag);

    // R8
    flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_flag) |-> $past(clr_cap_wr || cap_rd));

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R11
    swgen_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_gen |=> cap_flag);
endmodule

bind capch_top capch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_val(cap_val), .cap_flag(cap_flag),
    .ovr_flag(ovr_flag), .irq(irq), .irq_en(irq_en), .chan_en(chan_en),
    .sw_gen(sw_gen), .clr_cap_wr(clr_cap_wr), .clr_ovr_wr(clr_ovr_wr),
    .cap_rd(cap_rd)
);

// File: tb/capch_top_test.sv
`timescale 1ns/1ps
module capch_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_in = '0;
    logic        pin_in = 1'b0;
    logic        chan_en = 1'b0;
    logic        edge_pol = 1'b0;
    logic [3:0]  flt_code = '0;
    logic [1:0]  psc_code = '0;
    logic        irq_en = 1'b0;
    logic        sw_gen = 1'b0;
    logic        clr_cap_wr = 1'b0;
    logic        clr_ovr_wr = 1'b0;
    logic        cap_rd = 1'b0;
    logic [15:0] cap_val;
    logic        cap_flag;
    logic        ovr_flag;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] last_cap = '0;

    always #2.5 clk = ~clk;

    capch_top uut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .pin_in(pin_in),
        .chan_en(chan_en), .edge_pol(edge_pol), .flt_code(flt_code),
        .psc_code(psc_code), .irq_en(irq_en), .sw_gen(sw_gen),
        .clr_cap_wr(clr_cap_wr), .clr_ovr_wr(clr_ovr_wr), .cap_rd(cap_rd),
        .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  flt;
        logic        pol;
        logic [7:0]  width;
        logic [15:0] cnt;
        logic        hit;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'd0, 1'b0, 8'd1,  16'h1111, 1'b1},
        '{4'd0, 1'b1, 8'd1,  16'h2222, 1'b1},
        '{4'd1, 1'b0, 8'd1,  16'h3333, 1'b0},
        '{4'd1, 1'b0, 8'd2,  16'h4444, 1'b1},
        '{4'd3, 1'b0, 8'd7,  16'h5555, 1'b0},
        '{4'd3, 1'b0, 8'd8,  16'h6666, 1'b1},
        '{4'd3, 1'b1, 8'd8,  16'h7777, 1'b1},
        '{4'd2, 1'b1, 8'd3,  16'h8888, 1'b0},
        '{4'd4, 1'b0, 8'd16, 16'h9999, 1'b1},
        '{4'd4, 1'b1, 8'd15, 16'hAAAA, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flags();
        clr_cap_wr = 1'b1;
        clr_ovr_wr = 1'b1;
        ticks(1);
        clr_cap_wr = 1'b0;
        clr_ovr_wr = 1'b0;
        ticks(1);
    endtask

    // active-level pulse for the current polarity, then settle
    task automatic pulse(input int width);
        pin_in = ~edge_pol;
        ticks(width);
        pin_in = edge_pol;
        ticks(40);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        ticks(3);
        // R1 during reset
        chk("R1 flag in reset", cap_flag, 0);
        chk("R1 cap_val in reset", cap_val, 0);
        rst_n = 1'b1;
        ticks(2);
        chk("R1 flag", cap_flag, 0);
        chk("R1 ovr", ovr_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cap_val", cap_val, 0);

        // table walk: R2 R3 R4
        foreach (VECS[k]) begin
            chan_en  = 1'b0;
            edge_pol = VECS[k].pol;
            pin_in   = VECS[k].pol;
            flt_code = VECS[k].flt;
            psc_code = 2'd0;
            cnt_in   = VECS[k].cnt;
            ticks(40);
            clear_flags();
            chan_en = 1'b1;
            ticks(1);
            pulse(int'(VECS[k].width));
            if (VECS[k].hit) last_cap = VECS[k].cnt;
            chk($sformatf("R2/R3/R4 vec%0d flag", k), cap_flag, VECS[k].hit);
            chk($sformatf("R2/R4 vec%0d cap_val", k), cap_val, last_cap);
        end

        // R3: opposite edge only (falling edge in rising mode) captures nothing
        chan_en = 1'b0; edge_pol = 1'b0; flt_code = 4'd0; pin_in = 1'b1;
        ticks(20);
        clear_flags();
        chan_en = 1'b1; cnt_in = 16'hBEEF;
        pin_in = 1'b0;
        ticks(20);
        chk("R3 opposite edge flag", cap_flag, 0);
        chk("R3 opposite edge cap_val", cap_val, last_cap);

        // R7 / R8 overcapture and clearing
        clear_flags();
        cnt_in = 16'h0101; pulse(2);
        chk("R2 first capture flag", cap_flag, 1);
        cnt_in = 16'h0202; pulse(2);
        chk("R7 ovr after second capture", ovr_flag, 1);
        chk("R7 cap_val second", cap_val, 16'h0202);
        cap_rd = 1'b1; ticks(1); cap_rd = 1'b0; ticks(1);
        chk("R8 read clears flag", cap_flag, 0);
        chk("R8 read keeps ovr", ovr_flag, 1);
        clr_ovr_wr = 1'b1; ticks(1); clr_ovr_wr = 1'b0; ticks(1);
        chk("R8 ovr cleared by write", ovr_flag, 0);

        // R11 / R10 software generate and interrupt
        sw_gen = 1'b1; ticks(1); sw_gen = 1'b0; ticks(1);
        chk("R11 sw_gen sets flag", cap_flag, 1);
        chk("R11 cap_val unchanged", cap_val, 16'h0202);
        chk("R10 irq masked", irq, 0);
        sw_gen = 1'b1; ticks(1); sw_gen = 1'b0; ticks(1);
        chk("R7 sw_gen no ovr", ovr_flag, 0);
        irq_en = 1'b1; #1;
        chk("R10 irq enabled", irq, 1);
        clr_cap_wr = 1'b1; ticks(1); clr_cap_wr = 1'b0; ticks(1);
        chk("R8 write clears flag", cap_flag, 0);
        chk("R10 irq follows flag", irq, 0);
        irq_en = 1'b0;

        // R9 capture and read in the same cycle (filter code 0)
        sw_gen = 1'b1; ticks(1); sw_gen = 1'b0;
        cnt_in = 16'h0303;
        pin_in = 1'b1;          // before edge e1; capture at e4
        ticks(3);
        cap_rd = 1'b1;          // high across e4
        ticks(1);
        cap_rd = 1'b0;
        chk("R9 flag kept", cap_flag, 1);
        chk("R9 capture value", cap_val, 16'h0303);
        chk("R9 ovr set", ovr_flag, 1);
        pin_in = 1'b0; ticks(10);
        last_cap = 16'h0303;

        // R5 prescaler divide by 4
        clear_flags();
        psc_code = 2'd2;
        cnt_in = 16'h0404;
        for (int i = 0; i < 3; i++) pulse(2);
        chk("R5 three edges no capture", cap_flag, 0);
        chk("R5 cap_val held", cap_val, last_cap);
        pulse(2);
        chk("R5 fourth edge captures", cap_flag, 1);
        chk("R5 cap_val", cap_val, 16'h0404);
        last_cap = 16'h0404;

        // R6 disable clears prescaler count
        clear_flags();
        psc_code = 2'd1;
        cnt_in = 16'h0505;
        pulse(2);
        chan_en = 1'b0; ticks(2); chan_en = 1'b1; ticks(1);
        pulse(2);
        chk("R6 count restarted", cap_flag, 0);
        pulse(2);
        chk("R6 second edge captures", cap_flag, 1);
        last_cap = 16'h0505;

        // R6 disabled channel ignores edges
        clear_flags();
        psc_code = 2'd0;
        chan_en = 1'b0;
        cnt_in = 16'h0606;
        pulse(2);
        chk("R6 disabled flag", cap_flag, 0);
        chk("R6 disabled cap_val", cap_val, last_cap);

        finish_run();
    end
endmodule